// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves the received bytes of one serial channel into memory buffers. The buffers are described by a circular table of 8-byte descriptors. When a byte arrives and the engine is idle, it reads the descriptor at its current table pointer. If software has marked that descriptor as ready, the engine reads the buffer address from it and stores the incoming bytes one at a time at consecutive addresses. A remaining-space counter starts at one programmed maximum buffer length that is shared by all descriptors.

A buffer closes when its last byte slot is filled, when the frame ends, or when the channel reports an error. On closing, the engine writes the status and byte count back into the descriptor and moves to the next entry. After an entry whose wrap flag is set, it returns to the start of the table. If a descriptor is not ready, the engine flags itself busy and discards bytes up to the next frame boundary. The maximum length, table base and descriptor pointer can be written only while the receiver is disabled. Memory is reached through a request/acknowledge port, and the byte input is held back with a ready signal while an access is outstanding.

Top module: `rxbd_ring`

## Requirements
- R1: A write of the maximum buffer length (cfgSel = 0) is taken only if the value is a non-zero multiple of 32 that fits in 16 bits. Any other value leaves the register unchanged, and cfgErr is high for one cycle after the write.
- R2: Writes of the table base (cfgSel = 1) or of the descriptor pointer (cfgSel = 2) must be 8-byte aligned. An unaligned write is rejected and pulses cfgErr. An accepted base write also moves the descriptor pointer to that base.
- R3: A descriptor is two words. The word at the pointer holds status in bits 31:16 (bit 31 ready/empty, bit 30 wrap, bit 17 last-in-frame, bit 16 error) and the length in bits 15:0. The word at pointer+4 holds the buffer address. Only a descriptor with bit 31 set receives data.
- R4: A buffer never holds more bytes than the maximum length. When it fills before the frame ends, it closes with length equal to the maximum and neither last nor error set, and the frame continues in the next descriptor.
- R5: The bytes of a buffer are stored one per byte write (memByte = 1, data in bits 7:0) at consecutive addresses, starting at the buffer address.
- R6: Closing writes word 0 as {0, wrap, 12'b0, last, error, count}, with count equal to the number of bytes stored. Last is set when the buffer closes on an end-of-frame marker without error. Error is set when it closes on an error marker. The pointer then moves by 8, or back to the base if the wrap bit was set.
- R7: Configuration writes made while rxEnable is high are ignored: no register changes and cfgErr stays low.
- R8: If the fetched descriptor is not ready, busy goes high and bytes are accepted and discarded up to and including the next byte that carries an end or error marker. No memory write happens and the pointer stays where it is.
- R9: memReq, memAddr, memWData, memWr and memByte hold steady until memAck. inReady is low whenever memReq is high.
- R10: After reset, inReady, memReq, busy and cfgErr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receiver enable; blocks configuration writes while high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | 0 max length, 1 table base, 2 descriptor pointer |
| cfgWData | input | 32 | Configuration write value |
| cfgErr | output | 1 | One-cycle pulse after a rejected configuration value |
| inValid | input | 1 | Received byte present |
| inReady | output | 1 | Byte accepted on this edge when inValid is high |
| inData | input | 8 | Received byte |
| inEof | input | 1 | Byte is the last one of its frame |
| inErr | input | 1 | Byte ends the frame with an error |
| busy | output | 1 | Discarding a frame because no descriptor was ready |
| memReq | output | 1 | Memory access request |
| memAck | input | 1 | Memory access done (read data valid) |
| memWr | output | 1 | Access is a write |
| memByte | output | 1 | Write is a single byte in bits 7:0 |
| memAddr | output | ADDR_W | Byte address of the access |
| memWData | output | 32 | Write data |
| memRData | input | 32 | Read data, valid with memAck |

## Verification
The assertions check the memory handshake on every cycle: request, address and data stay steady until acknowledged, and bytes are never accepted during an access. They also check that every descriptor write clears the ready bit and carries a length equal to the bytes written since the previous close, that no memory is touched while discarding, and that cfgErr follows only a write made while disabled. Rejection of bad configuration values, the split of a long frame across two buffers, wrapping to the table base, skipping of a descriptor that is not ready, and the stored byte contents can only be shown by the bench scenarios, which compare each descriptor write-back and buffer content with values derived from the requirements.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  localparam int LEN_W = 16;
  localparam int WORD_W = 32;
  // status bit positions within descriptor word 0
  localparam int BIT_READY = 31;
  localparam int BIT_WRAP = 30;
  localparam int BIT_LAST = 17;
  localparam int BIT_ERR = 16;

  localparam logic [1:0] SEL_MAXLEN = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_PTR = 2'd2;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RD_STAT,
    OP_RD_ADDR,
    OP_WR_BYTE,
    OP_WR_STAT
  } memOp_t;

  typedef struct packed {
    memOp_t op;
    logic   loadWrap;
    logic   loadPtr;
    logic   storeByte;
    logic   byteDone;
    logic   advance;
  } strobes_t;
endpackage

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl
  import rxbd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxEnable,
  input  logic     inValid,
  input  logic     inEof,
  input  logic     inErr,
  input  logic     memAck,
  input  logic     descReady,
  input  logic     remOne,
  input  logic     holdEnd,
  output strobes_t stb,
  output logic     inReady,
  output logic     memReq,
  output logic     busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH_STAT, S_FETCH_ADDR, S_RECV, S_WRITE, S_CLOSE, S_DROP
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    stb.op        = OP_NONE;
    stb.loadWrap  = 1'b0;
    stb.loadPtr   = 1'b0;
    stb.storeByte = 1'b0;
    stb.byteDone  = 1'b0;
    stb.advance   = 1'b0;
    inReady       = 1'b0;
    case (state)
      S_IDLE: if (rxEnable && inValid) nextState = S_FETCH_STAT;
      S_FETCH_STAT: begin
        stb.op = OP_RD_STAT;
        if (memAck) begin
          stb.loadWrap = 1'b1;
          nextState = descReady ? S_FETCH_ADDR : S_DROP;
        end
      end
      S_FETCH_ADDR: begin
        stb.op = OP_RD_ADDR;
        if (memAck) begin
          stb.loadPtr = 1'b1;
          nextState = S_RECV;
        end
      end
      S_RECV: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.storeByte = 1'b1;
          nextState = S_WRITE;
        end
      end
      S_WRITE: begin
        stb.op = OP_WR_BYTE;
        if (memAck) begin
          stb.byteDone = 1'b1;
          nextState = (holdEnd || remOne) ? S_CLOSE : S_RECV;
        end
      end
      S_CLOSE: begin
        stb.op = OP_WR_STAT;
        if (memAck) begin
          stb.advance = 1'b1;
          nextState = S_IDLE;
        end
      end
      S_DROP: begin
        inReady = 1'b1;
        if (inValid && (inEof || inErr)) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign memReq = (stb.op != OP_NONE);
  assign busy   = (state == S_DROP);
endmodule

// File: rtl/rxbd_dpath.sv
module rxbd_dpath
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_RST = '0,
  parameter logic [LEN_W-1:0] MAXLEN_RST = 16'd64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [WORD_W-1:0] cfgWData,
  output logic              cfgErr,
  input  logic [7:0]        inData,
  input  logic              inEof,
  input  logic              inErr,
  input  strobes_t          stb,
  input  logic [WORD_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic              memWr,
  output logic              memByte,
  output logic              descReady,
  output logic              remOne,
  output logic              holdEnd
);
  localparam int LEN_ALIGN = 5;
  localparam int DESC_ALIGN = 3;
  localparam logic [ADDR_W-1:0] DESC_BYTES = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] ADDR_OFS = ADDR_W'(4);

  logic [ADDR_W-1:0] tableBase, descPtr, bufPtr;
  logic [LEN_W-1:0]  maxLen, remaining, count;
  logic [7:0]        holdData;
  logic              holdEof, holdErr, wrapFlag;

  logic [ADDR_W-1:0] cfgAddr;
  logic              lenOk, addrOk;
  assign cfgAddr = cfgWData[ADDR_W-1:0];
  assign lenOk   = (cfgWData[LEN_ALIGN-1:0] == '0) && (cfgWData[WORD_W-1:LEN_W] == '0)
                && (cfgWData[LEN_W-1:LEN_ALIGN] != '0);
  assign addrOk  = (cfgAddr[DESC_ALIGN-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tableBase <= BASE_RST;
      descPtr   <= BASE_RST;
      maxLen    <= MAXLEN_RST;
      cfgErr    <= 1'b0;
    end else begin
      cfgErr <= 1'b0;
      if (stb.advance) descPtr <= wrapFlag ? tableBase : descPtr + DESC_BYTES;
      if (cfgWe && !rxEnable) begin
        case (cfgSel)
          SEL_MAXLEN: if (lenOk) maxLen <= cfgWData[LEN_W-1:0]; else cfgErr <= 1'b1;
          SEL_BASE: begin
            if (addrOk) begin
              tableBase <= cfgAddr;
              descPtr   <= cfgAddr;
            end else cfgErr <= 1'b1;
          end
          SEL_PTR: if (addrOk) descPtr <= cfgAddr; else cfgErr <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufPtr    <= '0;
      remaining <= '0;
      count     <= '0;
      holdData  <= '0;
      holdEof   <= 1'b0;
      holdErr   <= 1'b0;
      wrapFlag  <= 1'b0;
    end else begin
      if (stb.loadWrap) wrapFlag <= memRData[BIT_WRAP];
      if (stb.loadPtr) begin
        bufPtr    <= memRData[ADDR_W-1:0];
        remaining <= maxLen;
        count     <= '0;
        holdEof   <= 1'b0;
        holdErr   <= 1'b0;
      end
      if (stb.storeByte) begin
        holdData <= inData;
        holdEof  <= inEof;
        holdErr  <= inErr;
      end
      if (stb.byteDone) begin
        bufPtr    <= bufPtr + ADDR_W'(1);
        remaining <= remaining - LEN_W'(1);
        count     <= count + LEN_W'(1);
      end
    end
  end

  logic closeLast;
  assign closeLast = holdEof && !holdErr;

  always_comb begin
    memAddr  = descPtr;
    memWData = '0;
    memWr    = 1'b0;
    memByte  = 1'b0;
    case (stb.op)
      OP_RD_ADDR: memAddr = descPtr + ADDR_OFS;
      OP_WR_BYTE: begin
        memAddr  = bufPtr;
        memWData = {24'b0, holdData};
        memWr    = 1'b1;
        memByte  = 1'b1;
      end
      OP_WR_STAT: begin
        memWData = {1'b0, wrapFlag, 12'b0, closeLast, holdErr, count};
        memWr    = 1'b1;
      end
      default: ;
    endcase
  end

  assign descReady = memRData[BIT_READY];
  assign remOne    = (remaining == LEN_W'(1));
  assign holdEnd   = holdEof || holdErr;
endmodule

// File: rtl/rxbd_ring.sv
module rxbd_ring
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_RST = '0,
  parameter logic [15:0] MAXLEN_RST = 16'd64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgWData,
  output logic              cfgErr,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  input  logic              inEof,
  input  logic              inErr,
  output logic              busy,
  output logic              memReq,
  input  logic              memAck,
  output logic              memWr,
  output logic              memByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWData,
  input  logic [31:0]       memRData
);
  strobes_t stb;
  logic descReady, remOne, holdEnd;

  rxbd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .inValid(inValid),
    .inEof(inEof), .inErr(inErr), .memAck(memAck), .descReady(descReady),
    .remOne(remOne), .holdEnd(holdEnd), .stb(stb), .inReady(inReady),
    .memReq(memReq), .busy(busy)
  );

  rxbd_dpath #(.ADDR_W(ADDR_W), .BASE_RST(BASE_RST), .MAXLEN_RST(MAXLEN_RST)) u_dp (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWData(cfgWData), .cfgErr(cfgErr), .inData(inData), .inEof(inEof),
    .inErr(inErr), .stb(stb), .memRData(memRData), .memAddr(memAddr),
    .memWData(memWData), .memWr(memWr), .memByte(memByte),
    .descReady(descReady), .remOne(remOne), .holdEnd(holdEnd)
  );
endmodule

// File: rtl/rxbd_ring_chk.sv
module rxbd_ring_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              cfgWe,
  input logic              cfgErr,
  input logic              inReady,
  input logic              busy,
  input logic              memReq,
  input logic              memAck,
  input logic              memWr,
  input logic              memByte,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWData
);
  logic [15:0] bytesSinceClose;

  always_ff @(posedge clk) begin
    if (!rstN) bytesSinceClose <= '0;
    else if (memReq && memAck && memWr)
      bytesSinceClose <= memByte ? bytesSinceClose + 16'd1 : 16'd0;
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWData)
                          && $stable(memWr) && $stable(memByte));

  a_r9_no_accept_during_mem: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !inReady);

  a_r8_drop_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !memReq);

  a_r6_close_clears_ready: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWr && !memByte |-> !memWData[31]);

  a_r6_len_matches_bytes: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWr && !memByte |-> memWData[15:0] == bytesSinceClose);

  a_r7_cfg_err_only_disabled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErr) |-> $past(cfgWe) && !$past(rxEnable));
endmodule

bind rxbd_ring rxbd_ring_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .cfgWe(cfgWe), .cfgErr(cfgErr),
  .inReady(inReady), .busy(busy), .memReq(memReq), .memAck(memAck),
  .memWr(memWr), .memByte(memByte), .memAddr(memAddr), .memWData(memWData)
);

// File: tb/rxbd_ring_tb.sv
module rxbd_ring_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0, cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [31:0] cfgWData = '0;
  logic cfgErr, inReady, busy, memReq, memWr, memByte;
  logic inValid = 1'b0, inEof = 1'b0, inErr = 1'b0, memAck = 1'b0;
  logic [7:0] inData = '0;
  logic [31:0] memAddr, memWData, memRData = '0;

  always #2.5 clk = ~clk;

  rxbd_ring u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWData(cfgWData), .cfgErr(cfgErr), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inEof(inEof), .inErr(inErr), .busy(busy), .memReq(memReq),
    .memAck(memAck), .memWr(memWr), .memByte(memByte), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData)
  );

  int nChecks = 0, nFail = 0;
  logic [7:0] mem [0:1023];
  logic [63:0] expQ [$];
  logic [63:0] seenDesc;
  event descWr;
  bit busySeen;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdWord(logic [31:0] a);
    return {mem[a[9:0]+3], mem[a[9:0]+2], mem[a[9:0]+1], mem[a[9:0]]};
  endfunction

  task automatic putWord(logic [31:0] a, logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[a[9:0]+k] = w[8*k +: 8];
  endtask

  // memory responder with varying latency; reports descriptor writes to the monitor
  initial begin
    int lat = 0, seed = 0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (lat > 0) lat--;
        else begin
          if (!memWr) memRData = rdWord(memAddr);
          else if (memByte) mem[memAddr[9:0]] = memWData[7:0];
          else begin
            putWord(memAddr, memWData);
            seenDesc = {memAddr, memWData};
            -> descWr;
          end
          memAck = 1'b1;
          seed++;
          lat = seed % 3;
        end
      end
    end
  end

  // scoreboard monitor
  initial forever begin
    @(descWr);
    if (expQ.size() == 0) check(1'b0, "R6", "unexpected descriptor write", seenDesc, '0);
    else begin
      logic [63:0] e;
      e = expQ.pop_front();
      check(seenDesc == e, "R6", "descriptor write-back {addr,word}", seenDesc, e);
    end
  end

  task automatic expectClose(logic [31:0] a, logic [31:0] w);
    expQ.push_back({a, w});
  endtask

  task automatic cfgWrite(logic [1:0] sel, logic [31:0] d, output logic err);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    err = cfgErr;
  endtask

  task automatic sendByte(logic [7:0] d, logic eof, logic er);
    inValid = 1'b1; inData = d; inEof = eof; inErr = er;
    while (!inReady) @(negedge clk);
    if (busy) busySeen = 1'b1;
    @(negedge clk);
    inValid = 1'b0; inEof = 1'b0; inErr = 1'b0;
  endtask

  task automatic sendFrame(int n, logic [7:0] first, logic endErr);
    for (int i = 0; i < n; i++)
      sendByte(8'(first + 8'(i)), (i == n-1) && !endErr, (i == n-1) && endErr);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && expQ.size() != 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, "R6", "pending descriptor closes", 64'(expQ.size()), 0);
  endtask

  task automatic checkBytes(string req, logic [31:0] a, logic [7:0] first, int n);
    bit ok = 1'b1;
    logic [7:0] bad = '0, want = '0;
    for (int i = 0; i < n; i++)
      if (mem[a[9:0] + i] !== 8'(first + 8'(i)) && ok) begin
        ok = 1'b0; bad = mem[a[9:0] + i]; want = 8'(first + 8'(i));
      end
    check(ok, req, "buffer contents", 64'(bad), 64'(want));
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run timed out", 0, 0);
    finish();
  end

  initial begin
    logic err;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check({inReady, memReq, busy, cfgErr} == 4'b0, "R10", "outputs after reset",
          64'({inReady, memReq, busy, cfgErr}), 0);

    // R1 length must be non-zero multiple of 32
    cfgWrite(2'd0, 32'd40, err); check(err == 1'b1, "R1", "cfgErr on length 40", 64'(err), 1);
    cfgWrite(2'd0, 32'd0, err);  check(err == 1'b1, "R1", "cfgErr on length 0", 64'(err), 1);
    cfgWrite(2'd0, 32'd32, err); check(err == 1'b0, "R1", "cfgErr on length 32", 64'(err), 0);
    // R2 alignment of base and pointer
    cfgWrite(2'd1, 32'h104, err); check(err == 1'b1, "R2", "cfgErr on base 0x104", 64'(err), 1);
    cfgWrite(2'd1, 32'h100, err); check(err == 1'b0, "R2", "cfgErr on base 0x100", 64'(err), 0);

    // R3 ring: three descriptors, last one wraps
    putWord(32'h100, 32'h8000_0000); putWord(32'h104, 32'h200);
    putWord(32'h108, 32'h8000_0000); putWord(32'h10C, 32'h240);
    putWord(32'h110, 32'hC000_0000); putWord(32'h114, 32'h280);
    rxEnable = 1'b1;

    // frame A: short frame ends with last bit (R3, R5, R6)
    expectClose(32'h100, 32'h0002_0005);
    sendFrame(5, 8'hA0, 1'b0);
    drain();
    checkBytes("R5", 32'h200, 8'hA0, 5);

    // frame B: 40 bytes split into 32 + 8, second buffer wraps (R4, R6)
    expectClose(32'h108, 32'h0000_0020);
    expectClose(32'h110, 32'h4002_0008);
    sendFrame(40, 8'hB0, 1'b0);
    drain();
    checkBytes("R4", 32'h240, 8'hB0, 32);
    check(mem[10'h260] == 8'h00, "R4", "byte past max length", 64'(mem[10'h260]), 0);
    checkBytes("R5", 32'h280, 8'hD0, 8);

    // frame C: pointer wrapped to base; descriptor 0 not ready -> discard (R8)
    busySeen = 1'b0;
    sendFrame(3, 8'hC0, 1'b1);
    repeat (40) @(negedge clk);
    check(busySeen, "R8", "busy during discarded frame", 64'(busySeen), 1);
    check(busy == 1'b0, "R8", "busy cleared after boundary", 64'(busy), 0);
    check(mem[10'h200] == 8'hA0, "R8", "buffer untouched while discarding", 64'(mem[10'h200]), 64'hA0);

    // frame D: re-armed descriptor 0, closed by error marker (R6, R8 pointer unchanged)
    putWord(32'h100, 32'h8000_0000);
    expectClose(32'h100, 32'h0001_0003);
    sendFrame(3, 8'hE0, 1'b1);
    drain();
    checkBytes("R5", 32'h200, 8'hE0, 3);

    // R7 configuration writes ignored while enabled
    cfgWrite(2'd0, 32'd64, err); check(err == 1'b0, "R7", "no cfgErr for length while enabled", 64'(err), 0);
    cfgWrite(2'd0, 32'd33, err); check(err == 1'b0, "R7", "no cfgErr for bad length while enabled", 64'(err), 0);
    cfgWrite(2'd2, 32'h100, err);
    putWord(32'h108, 32'h8000_0000);
    putWord(32'h110, 32'hC000_0000);
    // length still 32 and pointer still at descriptor 1
    expectClose(32'h108, 32'h0000_0020);
    expectClose(32'h110, 32'h4002_0004);
    sendFrame(36, 8'h10, 1'b0);
    drain();
    checkBytes("R7", 32'h280, 8'h30, 4);

    // R2 pointer write while disabled
    rxEnable = 1'b0;
    cfgWrite(2'd2, 32'h10C, err); check(err == 1'b1, "R2", "cfgErr on pointer 0x10C", 64'(err), 1);
    cfgWrite(2'd2, 32'h110, err); check(err == 1'b0, "R2", "cfgErr on pointer 0x110", 64'(err), 0);
    putWord(32'h110, 32'hC000_0000);
    rxEnable = 1'b1;
    expectClose(32'h110, 32'h4002_0002);
    sendFrame(2, 8'h70, 1'b0);
    drain();
    checkBytes("R2", 32'h280, 8'h70, 2);
    // R6 wrap returns to base: descriptor 0 is ready again
    putWord(32'h100, 32'h8000_0000);
    expectClose(32'h100, 32'h0002_0001);
    sendFrame(1, 8'h55, 1'b0);
    drain();
    finish();
  end
endmodule